// File: doc/BRIEF.md
# Syndrome Page Layout Address Mapper

The block translates a byte position in a raw NAND page into its place in the logical view of that page. The raw page interleaves the data of each ECC chunk with that chunk's check bytes, and it reserves a few bad-block-marker bytes at the start of the spare region. The logical view keeps all chunk data together as the data area. The spare area holds the marker bytes first, then every chunk's check bytes in chunk order, then the remaining free spare bytes.

For every physical index it receives, the mapper reports a region code (data, spare or fill) and the logical index within that region. A byte-stream engine beside it uses this result to scatter a raw read into the two logical buffers, or to gather them for a raw write.

The geometry is set at run time through the following inputs:
- page size and spare size
- chunk size and check bytes per chunk
- active chunk count
- marker skip

These inputs must stay stable while requests are in flight.

Top module: `syndrome_layout_mapper`

## Requirements
- R1: A request with `req_valid_i` high gives exactly one response with `rsp_valid_o` high two clock cycles later. Requests may arrive every cycle, and the responses keep their order.
- R2: Take a chunk i whose data segment lies wholly below the page size. Its data occupies physical bytes starting at i*(chunk+ecc) for chunk-size bytes. Each of those bytes reports region DATA (code 2'b01) with logical index i*chunk + offset.
- R3: Take a chunk i whose check-byte segment lies wholly below the page size. Its check bytes occupy physical bytes starting at chunk + i*(chunk+ecc) for ecc bytes. Each of those bytes reports region SPARE (code 2'b10) with logical index skip + i*ecc + offset.
- R4: A data or check segment whose nominal start is at or beyond the page size is moved forward by the skip count. The logical index it reports is unchanged.
- R5: A segment that starts below the page size but runs past it is cut at the page size. The bytes left over continue at physical offset page + skip, and the logical index carries on without a break.
- R6: Physical bytes page .. page+skip-1 report SPARE with logical index 0 .. skip-1 (the bad-block marker).
- R7: Let free = spare - skip - count*ecc. The last free physical bytes of the raw page report SPARE with logical index skip + count*ecc + j, which equals physical - page.
- R8: A physical index at or beyond page + spare reports FILL (code 2'b00) with logical index 0. FILL marks a byte that a raw write pads with 0xFF.
- R9: Chunks numbered at or above the active chunk count claim no bytes. In-range bytes that no segment claims report FILL with logical index 0.
- R10: While `rst_ni` is low, `rsp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_size_i | input | IDX_W | Main-area bytes per page |
| spare_size_i | input | IDX_W | Spare-area bytes per page |
| chunk_size_i | input | IDX_W | Data bytes per ECC chunk |
| ecc_bytes_i | input | IDX_W | Check bytes per chunk |
| chunk_cnt_i | input | CNT_W | Active chunks, at most MAX_CHUNKS |
| skip_bytes_i | input | IDX_W | Marker bytes reserved at the start of the spare region |
| req_valid_i | input | 1 | Request strobe |
| phys_idx_i | input | IDX_W | Physical byte index |
| rsp_valid_o | output | 1 | Response strobe |
| region_o | output | 2 | 00 fill, 01 data, 10 spare |
| log_idx_o | output | IDX_W | Logical index within the region |

## Verification
The bench keeps the default widths: MAX_CHUNKS of 8 and 16-bit indices. It drives five geometries at run time, with each index swept past the raw page end:
- a layout whose boundary falls exactly between segments
- a check-byte segment split across the page boundary
- a data segment split across the page boundary
- a short page where the last data chunk straddles the marker
- two active chunks on a page large enough to leave unclaimed holes

These geometries reach the shifted, split, marker, free-tail and unused-lane paths, and they show that idle lanes stay silent.

// File: rtl/sl_pkg.sv
package sl_pkg;
  typedef enum logic [1:0] {
    REG_FILL  = 2'b00,
    REG_DATA  = 2'b01,
    REG_SPARE = 2'b10
  } region_e;
endpackage

// File: rtl/sl_gap_stage.sv
module sl_gap_stage #(
  parameter int IDX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] page_size_i,
  input  logic [IDX_W-1:0] spare_size_i,
  input  logic [IDX_W-1:0] skip_bytes_i,
  input  logic [IDX_W:0]   free_len_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] phys_idx_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] q_o,
  output logic [IDX_W-1:0] rel_o,
  output logic             mark_o,
  output logic             live_o,
  output logic             tail_o
);
  localparam int EXT_W = IDX_W + 1;

  logic [EXT_W-1:0] p_x, w_x, gap_x, end_x, tail_x;
  logic             live_c;

  always_comb begin
    p_x    = {1'b0, phys_idx_i};
    w_x    = {1'b0, page_size_i};
    gap_x  = w_x + {1'b0, skip_bytes_i};
    end_x  = w_x + {1'b0, spare_size_i};
    tail_x = end_x - free_len_i;
    live_c = p_x < end_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      q_o    <= '0;
      rel_o  <= '0;
      mark_o <= 1'b0;
      live_o <= 1'b0;
      tail_o <= 1'b0;
    end else begin
      vld_o <= req_valid_i;
      if (req_valid_i) begin
        // collapse the marker gap so chunks tile a continuous space
        q_o    <= (p_x >= gap_x) ? phys_idx_i - skip_bytes_i : phys_idx_i;
        rel_o  <= phys_idx_i - page_size_i;
        mark_o <= (p_x >= w_x) && (p_x < gap_x) && live_c;
        live_o <= live_c;
        tail_o <= live_c && (free_len_i != '0) && (p_x >= tail_x);
      end
    end
  end

  // R1
  stage_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> vld_o);
  // R1
  stage_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !vld_o);
endmodule

// File: rtl/sl_chunk_lane.sv
module sl_chunk_lane #(
  parameter int IDX_W = 16,
  parameter int CNT_W = 4,
  parameter int LANE  = 0
) (
  input  logic [IDX_W-1:0] q_i,
  input  logic [IDX_W-1:0] chunk_size_i,
  input  logic [IDX_W-1:0] ecc_bytes_i,
  input  logic [IDX_W-1:0] skip_bytes_i,
  input  logic [CNT_W-1:0] chunk_cnt_i,
  output logic             data_hit_o,
  output logic             ecc_hit_o,
  output logic [IDX_W-1:0] data_idx_o,
  output logic [IDX_W-1:0] ecc_idx_o
);
  localparam int               EXT_W  = IDX_W + 1;
  localparam logic [EXT_W-1:0] LANE_X = EXT_W'(LANE);
  localparam logic [CNT_W:0]   LANE_C = (CNT_W+1)'(LANE);

  logic [EXT_W-1:0] q_x, s_x, e_x, k_x, start_x, ecc_x, end_x;
  logic             en;

  always_comb begin
    q_x     = {1'b0, q_i};
    s_x     = {1'b0, chunk_size_i};
    e_x     = {1'b0, ecc_bytes_i};
    k_x     = {1'b0, skip_bytes_i};
    en      = {1'b0, chunk_cnt_i} > LANE_C;
    start_x = (s_x + e_x) * LANE_X;
    ecc_x   = start_x + s_x;
    end_x   = ecc_x + e_x;
    data_hit_o = en && (q_x >= start_x) && (q_x < ecc_x);
    ecc_hit_o  = en && (q_x >= ecc_x) && (q_x < end_x);
    data_idx_o = IDX_W'(s_x * LANE_X + (q_x - start_x));
    ecc_idx_o  = IDX_W'(k_x + e_x * LANE_X + (q_x - ecc_x));
  end
endmodule

// File: rtl/syndrome_layout_mapper.sv
module syndrome_layout_mapper
  import sl_pkg::*;
#(
  parameter int IDX_W      = 16,
  parameter int MAX_CHUNKS = 8,
  parameter int CNT_W      = $clog2(MAX_CHUNKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] page_size_i,
  input  logic [IDX_W-1:0] spare_size_i,
  input  logic [IDX_W-1:0] chunk_size_i,
  input  logic [IDX_W-1:0] ecc_bytes_i,
  input  logic [CNT_W-1:0] chunk_cnt_i,
  input  logic [IDX_W-1:0] skip_bytes_i,
  input  logic             req_valid_i,
  input  logic [IDX_W-1:0] phys_idx_i,
  output logic             rsp_valid_o,
  output logic [1:0]       region_o,
  output logic [IDX_W-1:0] log_idx_o
);
  localparam int EXT_W = IDX_W + 1;

  logic [EXT_W-1:0] used_x, o_x, free_x;

  always_comb begin
    o_x    = {1'b0, spare_size_i};
    used_x = {1'b0, skip_bytes_i} + EXT_W'(chunk_cnt_i) * {1'b0, ecc_bytes_i};
    free_x = (o_x >= used_x) ? o_x - used_x : '0;
  end

  logic             s1_vld, s1_mark, s1_live, s1_tail;
  logic [IDX_W-1:0] s1_q, s1_rel;

  sl_gap_stage #(.IDX_W(IDX_W)) i_gap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .page_size_i  (page_size_i),
    .spare_size_i (spare_size_i),
    .skip_bytes_i (skip_bytes_i),
    .free_len_i   (free_x),
    .req_valid_i  (req_valid_i),
    .phys_idx_i   (phys_idx_i),
    .vld_o        (s1_vld),
    .q_o          (s1_q),
    .rel_o        (s1_rel),
    .mark_o       (s1_mark),
    .live_o       (s1_live),
    .tail_o       (s1_tail)
  );

  logic [MAX_CHUNKS-1:0] d_hit, e_hit;
  logic [IDX_W-1:0]      d_idx [MAX_CHUNKS];
  logic [IDX_W-1:0]      e_idx [MAX_CHUNKS];

  for (genvar g = 0; g < MAX_CHUNKS; g++) begin : g_lane
    sl_chunk_lane #(.IDX_W(IDX_W), .CNT_W(CNT_W), .LANE(g)) i_lane (
      .q_i          (s1_q),
      .chunk_size_i (chunk_size_i),
      .ecc_bytes_i  (ecc_bytes_i),
      .skip_bytes_i (skip_bytes_i),
      .chunk_cnt_i  (chunk_cnt_i),
      .data_hit_o   (d_hit[g]),
      .ecc_hit_o    (e_hit[g]),
      .data_idx_o   (d_idx[g]),
      .ecc_idx_o    (e_idx[g])
    );
  end

  region_e          nxt_region;
  logic [IDX_W-1:0] nxt_idx, d_sel, e_sel;

  always_comb begin
    d_sel = '0;
    e_sel = '0;
    for (int i = 0; i < MAX_CHUNKS; i++) begin
      if (d_hit[i]) d_sel = d_sel | d_idx[i];
      if (e_hit[i]) e_sel = e_sel | e_idx[i];
    end
    nxt_region = REG_FILL;
    nxt_idx    = '0;
    if (s1_mark) begin
      nxt_region = REG_SPARE;
      nxt_idx    = s1_rel;
    end else if (s1_live && |d_hit) begin
      nxt_region = REG_DATA;
      nxt_idx    = d_sel;
    end else if (s1_live && |e_hit) begin
      nxt_region = REG_SPARE;
      nxt_idx    = e_sel;
    end else if (s1_tail) begin
      nxt_region = REG_SPARE;
      nxt_idx    = s1_rel;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      region_o    <= REG_FILL;
      log_idx_o   <= '0;
    end else begin
      rsp_valid_o <= s1_vld;
      if (s1_vld) begin
        region_o  <= nxt_region;
        log_idx_o <= nxt_idx;
      end
    end
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |=> rsp_valid_o);
  // R1
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_vld |=> !rsp_valid_o);
  // R2
  lane_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_vld |-> $onehot0({d_hit, e_hit}));
  // R2
  data_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && region_o == REG_DATA) |->
      ({1'b0, log_idx_o} < EXT_W'(chunk_cnt_i) * {1'b0, chunk_size_i}));
  // R6
  marker_spare_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && s1_mark) |=> (region_o == REG_SPARE));
  // R8
  beyond_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_vld && !s1_live) |=> (region_o == REG_FILL && log_idx_o == '0));
  // R10
  reset_quiet_chk: assert property (@(posedge clk_i)
    !rst_ni |-> !rsp_valid_o);
endmodule

// File: tb/test_syndrome_layout_mapper.sv
`timescale 1ns/1ps
module test_syndrome_layout_mapper;
  localparam int IDX_W = 16;
  localparam int MAXC  = 8;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int cw, co, cs, ce, cn, ck;
  logic             req_valid = 1'b0;
  logic [IDX_W-1:0] phys = '0;
  logic             rsp_valid;
  logic [1:0]       region;
  logic [IDX_W-1:0] log_idx;

  syndrome_layout_mapper #(.IDX_W(IDX_W), .MAX_CHUNKS(MAXC)) i_syndrome_layout_mapper (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .page_size_i  (IDX_W'(cw)),
    .spare_size_i (IDX_W'(co)),
    .chunk_size_i (IDX_W'(cs)),
    .ecc_bytes_i  (IDX_W'(ce)),
    .chunk_cnt_i  (CNT_W'(cn)),
    .skip_bytes_i (IDX_W'(ck)),
    .req_valid_i  (req_valid),
    .phys_idx_i   (phys),
    .rsp_valid_o  (rsp_valid),
    .region_o     (region),
    .log_idx_o    (log_idx)
  );

  int tests = 0, fails = 0, cyc = 0;
  int    q_reg[$], q_idx[$], q_cyc[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic seg(input int p, input int pos, input int len, input int base,
                     input int rg, input string plain, inout bit hit,
                     inout int r, inout int ix, inout string tag);
    int rem;
    if (hit) return;
    if (pos >= cw) begin
      if (p >= pos + ck && p < pos + ck + len) begin
        hit = 1; r = rg; ix = base + p - pos - ck; tag = "R4";
      end
    end else if (pos + len > cw) begin
      rem = len - (cw - pos);
      if (p >= pos && p < cw) begin
        hit = 1; r = rg; ix = base + p - pos; tag = "R5";
      end else if (p >= cw + ck && p < cw + ck + rem) begin
        hit = 1; r = rg; ix = base + (cw - pos) + (p - cw - ck); tag = "R5";
      end
    end else if (p >= pos && p < pos + len) begin
      hit = 1; r = rg; ix = base + p - pos; tag = plain;
    end
  endtask

  task automatic ref_map(input int p, output int r, output int ix, output string tag);
    bit hit = 0;
    int fr = co - ck - cn * ce;
    r = 0; ix = 0; tag = "R9";
    if (p >= cw + co) begin
      tag = "R8";
      return;
    end
    if (p >= cw && p < cw + ck) begin
      r = 2; ix = p - cw; tag = "R6";
      return;
    end
    for (int i = 0; i < cn; i++) begin
      seg(p, i * (cs + ce), cs, i * cs, 1, "R2", hit, r, ix, tag);
      seg(p, cs + i * (cs + ce), ce, ck + i * ce, 2, "R3", hit, r, ix, tag);
    end
    if (!hit && fr > 0 && p >= cw + co - fr) begin
      r = 2; ix = ck + cn * ce + (p - (cw + co - fr)); tag = "R7";
    end
  endtask

  task automatic send(input int p);
    int r, ix;
    string tag;
    @(negedge clk);
    req_valid = 1'b1;
    phys = IDX_W'(p);
    ref_map(p, r, ix, tag);
    q_reg.push_back(r); q_idx.push_back(ix); q_tag.push_back(tag); q_cyc.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic sweep(input int w, input int o, input int s, input int e,
                       input int n, input int k);
    idle(4);
    cw = w; co = o; cs = s; ce = e; cn = n; ck = k;
    idle(2);
    for (int p = 0; p < w + o + 3; p++) begin
      send(p);
      if (p % 7 == 6) idle(1);
    end
    idle(4);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_reg.size() == 0) begin
        tests++; fails++;
        $display("FAIL R1 response with none pending: actual valid=1 expected valid=0");
      end else begin
        int er, ei, ec;
        string et;
        er = q_reg.pop_front(); ei = q_idx.pop_front();
        et = q_tag.pop_front(); ec = q_cyc.pop_front();
        tests++;
        if (region !== 2'(er) || log_idx !== IDX_W'(ei)) begin
          fails++;
          $display("FAIL %s region/idx actual %0d/%0d expected %0d/%0d", et, region, log_idx, er, ei);
        end
        tests++;
        if (cyc != ec + 2) begin
          fails++;
          $display("FAIL R1 latency actual %0d expected %0d", cyc - ec, 2);
        end
      end
    end
  end

  initial begin : watchdog
    #(5ns * 100000);
    fails++; tests++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cw = 32; co = 24; cs = 8; ce = 4; cn = 4; ck = 2;
    req_valid = 1'b1;
    phys = '0;
    repeat (3) @(negedge clk);
    tests++;
    if (rsp_valid !== 1'b0) begin // R10
      fails++;
      $display("FAIL R10 reset valid actual %0b expected 0", rsp_valid);
    end
    req_valid = 1'b0;
    rst_n = 1'b1;
    sweep(32, 24, 8, 4, 4, 2); // boundary between segments, shifted R4
    sweep(32, 20, 8, 3, 4, 2); // check bytes split R5
    sweep(32, 16, 8, 2, 4, 4); // data split R5
    sweep(16, 16, 8, 4, 2, 2); // short page R5/R7
    sweep(32, 16, 8, 4, 2, 2); // holes from unused lanes R9
    idle(6);
    tests++;
    if (q_reg.size() != 0) begin
      fails++;
      $display("FAIL R1 pending responses actual %0d expected 0", q_reg.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule